// File: doc/BRIEF.md
# Register-Direct Two-Operand ALU Executor

This block consumes an instruction byte stream, one byte per valid/ready transfer, and executes 32-bit integer instructions whose operands are named by an addressing byte that follows the opcode. It holds a file of eight 32-bit registers and three status flags: sign, zero and signed overflow. The supported operations are add, subtract, AND, OR, XOR, compare, copy, swap and a two-byte signed multiply. Only register-to-register operands are supported. Any memory operand form, any unknown opcode, and any unknown second byte after the escape byte raise a sticky error.

The register index that the ModR/M fields select is the same index used on the test ports. A preload port writes any register directly, and a peek port reads any register combinationally. These ports let a test harness set up operands and observe results without running instructions.

Top module: `regdirect_alu`

## Requirements
- R1: The addressing byte is split into mode = bits 7:6, reg = bits 5:3 and r/m = bits 2:0. Only mode 3 executes. Any other mode sets `err`, gives no `done` pulse and leaves all registers and flags unchanged.
- R2: Register numbers 0 to 7 select the same registers through the reg and r/m fields and through `preload_idx` and `peek_idx`. After reset, every register reads zero and all flags and `err` are low.
- R3: Opcodes 0x01, 0x29, 0x21, 0x09 and 0x31 write r/m with (r/m + reg), (r/m − reg), (r/m AND reg), (r/m OR reg) and (r/m XOR reg), each truncated to 32 bits. For example, register 0 = 0x10 and register 3 = 1 with bytes 01 D8 leave 0x00000011 in register 0.
- R4: Add and subtract set the sign flag from bit 31 of the result and the zero flag when the result is zero. They set the overflow flag when the exact signed result does not fit in 32 bits.
- R5: AND, OR and XOR clear the overflow flag and set the sign and zero flags from the result.
- R6: Opcode 0x39 computes r/m − reg and sets the flags exactly as subtract does, but writes no register.
- R7: Opcode 0x89 copies reg into r/m. Opcode 0x87 exchanges reg and r/m. Neither changes any flag, and both are harmless when reg equals r/m.
- R8: The escape byte 0x0F followed by 0xAF writes the low 32 bits of reg × r/m into reg and leaves the flags unchanged.
- R9: An opcode outside the supported set, or a second byte other than 0xAF after 0x0F, sets `err` and changes no register. The next byte is then taken as a fresh opcode. `err` stays high until reset.
- R10: `done` is high for exactly one cycle, in the cycle after the addressing byte of a successful instruction is accepted. The new register and flag values are visible in that same cycle.
- R11: While `preload_en` is high, `in_ready` is low and `preload_data` is written to register `preload_idx` at the clock edge. At all other times `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte is valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can accept a byte |
| done | output | 1 | One-cycle retire pulse |
| err | output | 1 | Sticky decode/mode error |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_ovf | output | 1 | Signed overflow flag |
| preload_en | input | 1 | Register preload strobe |
| preload_idx | input | 3 | Register number to preload |
| preload_data | input | 32 | Preload value |
| peek_idx | input | 3 | Register number to read |
| peek_data | output | 32 | Register contents |

## Verification
The bench targets signed overflow at both ends of the range (0x7FFFFFFF + 1 and 0x80000000 − 1). A design that derived overflow from the unsigned carry would flag these wrongly, or miss them. It exercises compare against equal, lesser and greater operands and then reads back the r/m register; a compare that wrote back would corrupt it. Copy and exchange run with reg equal to r/m and with stale flags present. A design that updated flags on these, or wrote the wrong half of a swap, shows a mismatch at once. Memory-mode bytes, unknown opcodes and a bad escape byte are sent mid-stream. A design that wrote registers, pulsed `done` or lost byte alignment afterwards is caught by the model on the following instruction.

// File: rtl/regdirect_alu.sv
module regdirect_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   in_byte,
  output logic         in_ready,
  output logic         done,
  output logic         err,
  output logic         flag_sign,
  output logic         flag_zero,
  output logic         flag_ovf,
  input  logic         preload_en,
  input  logic [2:0]   preload_idx,
  input  logic [W-1:0] preload_data,
  input  logic [2:0]   peek_idx,
  output logic [W-1:0] peek_data
);
  localparam int MSB = W - 1;
  localparam int NREG = 8;

  typedef enum logic [1:0] {ST_OP = 2'd0, ST_EXT = 2'd1, ST_MRM = 2'd2} st_t;

  st_t          state_q;
  logic [7:0]   op_q;
  logic         two_q;
  logic [W-1:0] rf [NREG];

  wire       fire = in_valid & in_ready;
  wire [1:0] md   = in_byte[7:6];
  wire [2:0] rg   = in_byte[5:3];
  wire [2:0] rm   = in_byte[2:0];

  assign in_ready  = ~preload_en;
  assign peek_data = rf[peek_idx];

  wire [W-1:0] a    = rf[rm];
  wire [W-1:0] b    = rf[rg];
  wire [W-1:0] sum  = a + b;
  wire [W-1:0] diff = a - b;
  wire [W-1:0] prod = a * b;
  wire ovf_add = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  wire ovf_sub = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);

  function automatic logic known_op(input logic [7:0] o);
    return o == 8'h01 || o == 8'h29 || o == 8'h21 || o == 8'h09 ||
           o == 8'h31 || o == 8'h39 || o == 8'h89 || o == 8'h87;
  endfunction

  logic         wr_rm, wr_rg, fl_upd, f_o;
  logic [W-1:0] res_rm, res_rg, res_f;

  always_comb begin
    wr_rm  = 1'b0;
    wr_rg  = 1'b0;
    fl_upd = 1'b0;
    f_o    = 1'b0;
    res_rm = b;
    res_rg = a;
    res_f  = '0;
    if (two_q) begin
      wr_rg  = 1'b1;
      res_rg = prod;
    end else begin
      case (op_q)
        8'h01: begin wr_rm = 1'b1; res_rm = sum;   fl_upd = 1'b1; res_f = sum;   f_o = ovf_add; end
        8'h29: begin wr_rm = 1'b1; res_rm = diff;  fl_upd = 1'b1; res_f = diff;  f_o = ovf_sub; end
        8'h21: begin wr_rm = 1'b1; res_rm = a & b; fl_upd = 1'b1; res_f = a & b; end
        8'h09: begin wr_rm = 1'b1; res_rm = a | b; fl_upd = 1'b1; res_f = a | b; end
        8'h31: begin wr_rm = 1'b1; res_rm = a ^ b; fl_upd = 1'b1; res_f = a ^ b; end
        8'h39: begin fl_upd = 1'b1; res_f = diff; f_o = ovf_sub; end
        8'h89: begin wr_rm = 1'b1; res_rm = b; end
        8'h87: begin wr_rm = 1'b1; wr_rg = 1'b1; res_rm = b; res_rg = a; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_OP;
      op_q      <= 8'h00;
      two_q     <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      flag_sign <= 1'b0;
      flag_zero <= 1'b0;
      flag_ovf  <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      done <= 1'b0;
      if (preload_en) rf[preload_idx] <= preload_data;
      if (fire) begin
        case (state_q)
          ST_OP: begin
            if (in_byte == 8'h0F) begin
              state_q <= ST_EXT;
            end else if (known_op(in_byte)) begin
              op_q    <= in_byte;
              two_q   <= 1'b0;
              state_q <= ST_MRM;
            end else begin
              err <= 1'b1;
            end
          end
          ST_EXT: begin
            if (in_byte == 8'hAF) begin
              two_q   <= 1'b1;
              state_q <= ST_MRM;
            end else begin
              err     <= 1'b1;
              state_q <= ST_OP;
            end
          end
          default: begin
            state_q <= ST_OP;
            if (md == 2'b11) begin
              if (wr_rm) rf[rm] <= res_rm;
              if (wr_rg) rf[rg] <= res_rg;
              if (fl_upd) begin
                flag_sign <= res_f[MSB];
                flag_zero <= (res_f == '0);
                flag_ovf  <= f_o;
              end
              done <= 1'b1;
            end else begin
              err <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/regdirect_alu_chk.sv
module regdirect_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_byte,
  input logic       done,
  input logic       err,
  input logic       flag_sign,
  input logic       flag_zero,
  input logic       flag_ovf,
  input logic [1:0] st
);
  wire fire = in_valid && in_ready;
  wire op_ok = in_byte == 8'h01 || in_byte == 8'h29 || in_byte == 8'h21 ||
               in_byte == 8'h09 || in_byte == 8'h31 || in_byte == 8'h39 ||
               in_byte == 8'h89 || in_byte == 8'h87 || in_byte == 8'h0F;

  a_r1_mem_mode_err: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && st == 2'd2 && in_byte[7:6] != 2'b11) |=> (err && !done));

  a_r9_unknown_op_err: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && st == 2'd0 && !op_ok) |=> err);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_after_mrm: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && st == 2'd2 && in_byte[7:6] == 2'b11) |=> done);

  a_r4_flags_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable({flag_sign, flag_zero, flag_ovf}));

  a_r5_zero_not_negative: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_sign && flag_zero));
endmodule

bind regdirect_alu regdirect_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_byte(in_byte), .done(done), .err(err), .flag_sign(flag_sign),
  .flag_zero(flag_zero), .flag_ovf(flag_ovf), .st(state_q)
);

// File: tb/regdirect_alu_tb.sv
module regdirect_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready, done, err, flag_sign, flag_zero, flag_ovf;
  logic        preload_en = 1'b0;
  logic [2:0]  preload_idx = 3'd0;
  logic [31:0] preload_data = 32'd0;
  logic [2:0]  peek_idx = 3'd0;
  logic [31:0] peek_data;

  regdirect_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .done(done), .err(err), .flag_sign(flag_sign),
    .flag_zero(flag_zero), .flag_ovf(flag_ovf), .preload_en(preload_en),
    .preload_idx(preload_idx), .preload_data(preload_data),
    .peek_idx(peek_idx), .peek_data(peek_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference
  logic [31:0] m_rf [8];
  bit m_s, m_z, m_o, m_err, m_done;
  int m_phase = 0;   // 0 opcode, 1 after escape, 2 addressing byte
  int m_op = 0;
  bit m_mul = 0;

  task automatic set_arith(input longint exact);
    logic [31:0] r;
    r = exact[31:0];
    m_s = r[31];
    m_z = (r == 0);
    m_o = (exact != longint'($signed(r)));
  endtask

  task automatic set_logic(input logic [31:0] r);
    m_s = r[31]; m_z = (r == 0); m_o = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_rf[i] = 0;
      {m_s, m_z, m_o, m_err, m_done} = 0;
      m_phase = 0; m_mul = 0;
    end else begin
      m_done = 0;
      if (preload_en) m_rf[preload_idx] = preload_data;
      else if (in_valid) begin
        if (m_phase == 0) begin
          if (in_byte == 8'h0F) m_phase = 1;
          else if (in_byte inside {8'h01, 8'h29, 8'h21, 8'h09, 8'h31, 8'h39, 8'h89, 8'h87}) begin
            m_op = in_byte; m_mul = 0; m_phase = 2;
          end else m_err = 1;
        end else if (m_phase == 1) begin
          if (in_byte == 8'hAF) begin m_mul = 1; m_phase = 2; end
          else begin m_err = 1; m_phase = 0; end
        end else begin
          int d, s;
          longint x, y;
          logic [31:0] t;
          m_phase = 0;
          d = in_byte[2:0];
          s = in_byte[5:3];
          x = longint'($signed(m_rf[d]));
          y = longint'($signed(m_rf[s]));
          if (in_byte[7:6] != 2'b11) m_err = 1;
          else begin
            m_done = 1;
            if (m_mul) begin
              t = 32'(x * y);
              m_rf[s] = t;
            end else case (m_op)
              'h01: begin set_arith(x + y); m_rf[d] = 32'(x + y); end
              'h29: begin set_arith(x - y); m_rf[d] = 32'(x - y); end
              'h39: set_arith(x - y);
              'h21: begin t = m_rf[d] & m_rf[s]; set_logic(t); m_rf[d] = t; end
              'h09: begin t = m_rf[d] | m_rf[s]; set_logic(t); m_rf[d] = t; end
              'h31: begin t = m_rf[d] ^ m_rf[s]; set_logic(t); m_rf[d] = t; end
              'h89: m_rf[d] = m_rf[s];
              'h87: begin t = m_rf[d]; m_rf[d] = m_rf[s]; m_rf[s] = t; end
              default: ;
            endcase
          end
        end
      end
    end
  end

  task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp("R10 done", 32'(done), 32'(m_done));
      cmp("R9 R1 err", 32'(err), 32'(m_err));
      cmp("R4 R5 R6 flags", {29'd0, flag_sign, flag_zero, flag_ovf}, {29'd0, m_s, m_z, m_o});
      cmp("R11 in_ready", 32'(in_ready), 32'(!preload_en));
      cmp("R2 R3 peek", peek_data, m_rf[peek_idx]);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load(input int idx, input logic [31:0] v);
    preload_en = 1; preload_idx = 3'(idx); preload_data = v;
    tick();
    preload_en = 0;
  endtask

  task automatic put(input logic [7:0] bt);
    in_valid = 1; in_byte = bt;
    tick();
    in_valid = 0;
  endtask

  task automatic peek_chk(input string tag, input int idx, input logic [31:0] exp);
    peek_idx = 3'(idx);
    #1;
    cmp(tag, peek_data, exp);
  endtask

  task automatic flag_chk(input string tag, input bit s, input bit z, input bit o);
    cmp(tag, {29'd0, flag_sign, flag_zero, flag_ovf}, {29'd0, s, z, o});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    for (int i = 0; i < 8; i++) peek_chk("R2 reset reg", i, 32'd0);
    cmp("R2 reset err", 32'(err), 32'd0);

    // R3 add example
    load(0, 32'h10); load(3, 32'h1);
    put(8'h01); put(8'hD8);
    cmp("R10 done after addressing byte", 32'(done), 32'd1);
    peek_chk("R3 add", 0, 32'h11);
    tick();
    cmp("R10 done one cycle", 32'(done), 32'd0);

    put(8'h29); put(8'hD8);
    peek_chk("R3 sub", 0, 32'h10);

    // R4 overflow at top
    load(1, 32'h7FFFFFFF); load(2, 32'h1);
    put(8'h01); put(8'hD1);
    peek_chk("R4 add ovf value", 1, 32'h80000000);
    flag_chk("R4 add ovf flags", 1, 0, 1);
    // R4 overflow at bottom: 0x80000000 - 1
    put(8'h29); put(8'hD1);
    peek_chk("R4 sub ovf value", 1, 32'h7FFFFFFF);
    flag_chk("R4 sub ovf flags", 0, 0, 1);
    // R5 bitwise clears overflow
    load(4, 32'h0A0B0C0D); load(5, 32'hA0B0C0D0);
    put(8'h09); put(8'hEC);   // reg 5, r/m 4
    peek_chk("R3 or", 4, 32'hAABBCCDD);
    flag_chk("R5 or flags", 1, 0, 0);
    put(8'h31); put(8'hE4);   // r4 ^= r4
    peek_chk("R3 xor self", 4, 32'h0);
    flag_chk("R5 xor zero flags", 0, 1, 0);
    load(4, 32'h0A0B0C0D); load(5, 32'h000000FF);
    put(8'h21); put(8'hEC);
    peek_chk("R3 and", 4, 32'h0000000D);

    // R6 compare
    load(0, 32'h0A0B0C07); load(3, 32'h0A0B0C0D);
    put(8'h39); put(8'hD8);
    peek_chk("R6 cmp no write", 0, 32'h0A0B0C07);
    flag_chk("R6 cmp lesser", 1, 0, 0);
    load(3, 32'h0A0B0C07);
    put(8'h39); put(8'hD8);
    flag_chk("R6 cmp equal", 0, 1, 0);

    // R7 copy/exchange, flags untouched (zero flag still set)
    load(6, 32'hAF); load(7, 32'h2E);
    put(8'h87); put(8'hF7);   // reg 6, r/m 7
    peek_chk("R7 xchg rm", 7, 32'hAF);
    peek_chk("R7 xchg reg", 6, 32'h2E);
    flag_chk("R7 flags kept", 0, 1, 0);
    put(8'h87); put(8'hF6);   // reg 6 with itself
    peek_chk("R7 xchg self", 6, 32'h2E);
    put(8'h89); put(8'hF0);   // copy r6 -> r0
    peek_chk("R7 mov", 0, 32'h2E);

    // R8 multiply
    load(0, 32'h4); load(3, 32'hFFFFFFFE);
    put(8'h0F); put(8'hAF); put(8'hD8);
    peek_chk("R8 imul", 3, 32'hFFFFFFF8);
    flag_chk("R8 flags kept", 0, 1, 0);

    // random stream of good instructions, with gaps and preloads
    for (int k = 0; k < 400; k++) begin
      int pick;
      logic [7:0] ops [9];
      ops = '{8'h01, 8'h29, 8'h21, 8'h09, 8'h31, 8'h39, 8'h89, 8'h87, 8'h0F};
      pick = $urandom_range(0, 8);
      if ($urandom_range(0, 3) == 0) load($urandom_range(0, 7), $urandom);
      peek_idx = 3'($urandom_range(0, 7));
      put(ops[pick]);
      if (ops[pick] == 8'h0F) put(8'hAF);
      if ($urandom_range(0, 2) == 0) tick();
      put({2'b11, 6'($urandom)});
    end

    // R1 memory mode rejected
    load(0, 32'h55); load(3, 32'h1);
    put(8'h01); put(8'h18);
    peek_chk("R1 mem mode no write", 0, 32'h55);
    cmp("R1 mem mode err", 32'(err), 32'd1);
    put(8'h01); put(8'hD8);
    peek_chk("R9 resync after error", 0, 32'h56);
    // R9 unknown opcode and bad escape
    put(8'h55); put(8'h01); put(8'hD8);
    peek_chk("R9 unknown opcode skipped", 0, 32'h57);
    put(8'h0F); put(8'h00); put(8'h29); put(8'hD8);
    peek_chk("R9 bad escape skipped", 0, 32'h56);
    cmp("R9 err sticky", 32'(err), 32'd1);

    rst_n = 0; tick(); rst_n = 1; tick();
    cmp("R2 err cleared by reset", 32'(err), 32'd0);
    peek_chk("R2 reg cleared by reset", 0, 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule